// File: doc/BRIEF.md
# Prescaled 64-bit global timer

This block holds a 64-bit up-counter shared by several processors. While its enable bit is set, the counter advances by one every (prescaler + 1) cycles of the input clock. The prescaler is an 8-bit field of the control register. Software reaches the block through a 32-bit register port. Each access carries a requester index that names the processor making it. The counter is seen as two 32-bit words. Software may load either word only while the timer is stopped.

The control register combines two kinds of fields. The enable bit and the prescaler are shared by all processors. Three bits are kept in a separate copy for each processor: compare enable, interrupt enable and auto-increment. A write updates the shared fields and the requester's own copy of the per-processor bits. A read returns the shared fields merged with the requester's own bits.

The running count, an advance strobe, the enable state and each processor's three control bits are driven out to the comparator units that sit beside this block. Those units also own the interrupt-status, comparator and auto-increment offsets.

Top module: `gtmr_global_timer`

## Requirements
- R1: A cycle with `rst_n` low clears the count, the enable, the prescaler and every processor's banked bits. In the cycle after reset is released, `count_o`, `run_o` and all banked outputs are zero, and a control read returns zero.
- R2: Enable is control bit 0 at offset 0x08, and the prescaler P is control bits 15:8. While enable is set, the count rises by one every P+1 cycles. If enable is written at clock edge E, the first increment lands at edge E+P+1. The count is 64 bits wide, so a carry out of the low word rises into the high word.
- R3: While enable is clear and no accepted count write occurs, the count holds its value.
- R4: While enable is clear, a write to offset 0x00 replaces count bits 31:0, and a write to offset 0x04 replaces bits 63:32. The other word is left unchanged.
- R5: While enable is set, writes to offsets 0x00 and 0x04 have no effect.
- R6: A control write stores bit 0 and bits 15:8 in the shared copy. It stores bits 3:1 in the requester's own copy: bit 1 is compare enable, bit 2 is interrupt enable and bit 3 is auto-increment. All other bits are discarded.
- R7: A control read returns the shared enable in bit 0 and the prescaler in bits 15:8. It returns the requester's banked bits in 3:1, and all other bits read as zero.
- R8: A read of offset 0x00 or 0x04 returns the low or high word of the current count.
- R9: An access whose byte enables are not all four set is not a valid 32-bit access. Such a write has no effect, and such a read returns zero.
- R10: Any offset other than 0x00, 0x04 or 0x08 reads as zero, and a write to it has no effect. This includes unaligned offsets and the comparator-side offsets 0x0C to 0x18.
- R11: An access whose requester index is NUM_CPU or above is ignored. Its write changes nothing, and its read returns zero.
- R12: `rd_data_o` is zero in every cycle without a valid read request. During a read request it shows the value within the same cycle.
- R13: `count_tick_o` is high in exactly the cycles at whose closing edge the count advances. `cmp_en_o`, `irq_en_o` and `auto_inc_o` each carry one processor's stored banked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_be_i | input | WORD_W/8 | Byte enables; all must be set |
| req_cpu_i | input | CPU_W | Index of the requesting processor |
| req_wdata_i | input | WORD_W | Write data |
| rd_data_o | output | WORD_W | Read data, same cycle |
| count_o | output | 2*WORD_W | Current count |
| count_tick_o | output | 1 | Count advances at the next edge |
| run_o | output | 1 | Shared enable state |
| cmp_en_o | output | NUM_CPU | Per-processor compare enable |
| irq_en_o | output | NUM_CPU | Per-processor interrupt enable |
| auto_inc_o | output | NUM_CPU | Per-processor auto-increment |

## Verification
A divider phase that drifts shows up as a `count_tick_o` pulse in the wrong cycle and a count that is one step off. The bench compares both at every clock, so such an error is seen within P+1 cycles of its cause. A count write that slips through while running, or a lost carry into the high word, changes `count_o` at the very next edge. A banked bit stored in the wrong processor's copy appears at once on the per-processor outputs. It also appears in the control read from each requester. The reference model tracks the exact divider phase, so any cycle-level slip in enabling, disabling or changing the prescaler during a run is caught on the clock where the two disagree.

// File: rtl/gtmr_pkg.sv
// Shared constants and types for the global timer.
// Assumes a byte-addressed 32-bit register port; offsets below are byte offsets.
package gtmr_pkg;
    localparam int OFF_CNT_LO = 'h00;
    localparam int OFF_CNT_HI = 'h04;
    localparam int OFF_CTRL   = 'h08;

    localparam int RUN_BIT    = 0;
    localparam int BANK_LSB   = 1;
    localparam int BANK_W     = 3;
    localparam int PRESC_LSB  = 8;

    // Per-processor control copy; packed msb first, so cmp_en lands on control bit 1.
    typedef struct packed {
        logic auto_inc;
        logic irq_en;
        logic cmp_en;
    } bank_t;
endpackage

// File: rtl/gtmr_prescaler.sv
// Divider that issues one advance strobe every (presc_i + 1) cycles while running.
// Assumes presc_i may change at any time; a phase already past the new limit fires at once.
module gtmr_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tick_o
);
    logic [PRESC_W-1:0] div_q;

    // Strobe when the phase has reached the programmed limit.
    assign tick_o = run_i && (div_q >= presc_i);

    // Phase counter: cleared when stopped or on a strobe, otherwise counts up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/gtmr_counter.sv
// Wide up-counter built from WORDS words, each loadable on its own.
// Assumes the caller only raises a word load when the counter is stopped.
module gtmr_counter #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 2,
    localparam int CNT_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [WORDS-1:0]  wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  count_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_d;

    // Merge the write data into each selected word of the current count.
    always_comb begin
        load_d = cnt_q;
        for (int w = 0; w < WORDS; w++) begin
            if (wr_i[w]) begin
                load_d[w*WORD_W +: WORD_W] = wdata_i;
            end
        end
    end

    // Count register: an advance strobe wins over word loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= load_d;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/gtmr_ctrl_bank.sv
// Control storage: shared enable and prescaler, plus one banked copy per processor.
// Assumes sel_i is in range whenever wr_i is high; reads merge shared and selected bits.
module gtmr_ctrl_bank
    import gtmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2,
    parameter int WORD_W  = 32,
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [CPU_W-1:0]   sel_i,
    input  logic               run_d_i,
    input  logic [PRESC_W-1:0] presc_d_i,
    input  bank_t              bank_d_i,
    output logic               run_o,
    output logic [PRESC_W-1:0] presc_o,
    output bank_t              bank_o [NUM_CPU],
    output logic [WORD_W-1:0]  rd_ctrl_o
);
    logic               run_q;
    logic [PRESC_W-1:0] presc_q;
    bank_t              bank_q [NUM_CPU];
    bank_t              sel_bank;

    // Shared fields, written by any processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            presc_q <= '0;
        end else if (wr_i) begin
            run_q   <= run_d_i;
            presc_q <= presc_d_i;
        end
    end

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_bank
        // Banked copy for processor g, written only by that requester.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_i && (sel_i == CPU_W'(g))) begin
                bank_q[g] <= bank_d_i;
            end
        end
        assign bank_o[g] = bank_q[g];
    end

    // Pick the requester's banked copy for the read path.
    always_comb begin
        sel_bank = '0;
        for (int g = 0; g < NUM_CPU; g++) begin
            if (sel_i == CPU_W'(g)) begin
                sel_bank = bank_q[g];
            end
        end
    end

    // Assemble the control read word.
    always_comb begin
        rd_ctrl_o                      = '0;
        rd_ctrl_o[RUN_BIT]             = run_q;
        rd_ctrl_o[BANK_LSB +: BANK_W]  = sel_bank;
        rd_ctrl_o[PRESC_LSB +: PRESC_W] = presc_q;
    end

    assign run_o   = run_q;
    assign presc_o = presc_q;
endmodule

// File: rtl/gtmr_global_timer.sv
// Top of the global timer: register decode, access qualification and wiring of
// the divider, counter and control storage. Assumes one access per cycle and
// that reads are taken combinationally in the cycle of the request.
module gtmr_global_timer
    import gtmr_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int PRESC_W  = 8,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int BE_W    = WORD_W / 8,
    localparam int WORDS   = 2,
    localparam int CNT_W   = WORD_W * WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [BE_W-1:0]    req_be_i,
    input  logic [CPU_W-1:0]   req_cpu_i,
    input  logic [WORD_W-1:0]  req_wdata_i,
    output logic [WORD_W-1:0]  rd_data_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               count_tick_o,
    output logic               run_o,
    output logic [NUM_CPU-1:0] cmp_en_o,
    output logic [NUM_CPU-1:0] irq_en_o,
    output logic [NUM_CPU-1:0] auto_inc_o
);
    logic               acc_ok;
    logic               wr_ok;
    logic               hit_lo;
    logic               hit_hi;
    logic               hit_ctrl;
    logic               run;
    logic               tick;
    logic [PRESC_W-1:0] presc;
    logic [WORDS-1:0]   cnt_wr;
    logic [WORD_W-1:0]  rd_ctrl;
    logic [CNT_W-1:0]   count;
    bank_t              banks [NUM_CPU];

    // Qualify the access: full word, requester index in range.
    assign acc_ok = req_valid_i && (&req_be_i)
                    && ({1'b0, req_cpu_i} < (CPU_W+1)'(NUM_CPU));
    assign wr_ok  = acc_ok && req_write_i;

    // Offset decode.
    assign hit_lo   = (req_addr_i == ADDR_W'(OFF_CNT_LO));
    assign hit_hi   = (req_addr_i == ADDR_W'(OFF_CNT_HI));
    assign hit_ctrl = (req_addr_i == ADDR_W'(OFF_CTRL));

    // Count word loads are refused while the timer runs.
    assign cnt_wr = {wr_ok && hit_hi && !run, wr_ok && hit_lo && !run};

    gtmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .presc_i (presc),
        .tick_o  (tick)
    );

    gtmr_counter #(.WORD_W(WORD_W), .WORDS(WORDS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_i    (cnt_wr),
        .wdata_i (req_wdata_i),
        .count_o (count)
    );

    gtmr_ctrl_bank #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W),
        .WORD_W  (WORD_W),
        .PRESC_W (PRESC_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_ok && hit_ctrl),
        .sel_i     (req_cpu_i),
        .run_d_i   (req_wdata_i[RUN_BIT]),
        .presc_d_i (req_wdata_i[PRESC_LSB +: PRESC_W]),
        .bank_d_i  (bank_t'(req_wdata_i[BANK_LSB +: BANK_W])),
        .run_o     (run),
        .presc_o   (presc),
        .bank_o    (banks),
        .rd_ctrl_o (rd_ctrl)
    );

    // Read mux: zero unless a qualified read hits a defined offset.
    always_comb begin
        rd_data_o = '0;
        if (acc_ok && !req_write_i) begin
            if (hit_lo) begin
                rd_data_o = count[WORD_W-1:0];
            end else if (hit_hi) begin
                rd_data_o = count[CNT_W-1:WORD_W];
            end else if (hit_ctrl) begin
                rd_data_o = rd_ctrl;
            end
        end
    end

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_out
        assign cmp_en_o[g]   = banks[g].cmp_en;
        assign irq_en_o[g]   = banks[g].irq_en;
        assign auto_inc_o[g] = banks[g].auto_inc;
    end

    assign count_o      = count;
    assign count_tick_o = tick;
    assign run_o        = run;
endmodule

// File: rtl/gtmr_global_timer_chk.sv
// Property checker for the global timer, bound to every instance of the top.
// Assumes the same parameters as the instance it is bound to.
module gtmr_global_timer_chk #(
    parameter int NUM_CPU  = 4,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 5,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int BE_W    = WORD_W / 8,
    localparam int CNT_W   = WORD_W * 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [BE_W-1:0]   req_be_i,
    input logic [CPU_W-1:0]  req_cpu_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              count_tick_o,
    input logic              run_o
);
    logic cnt_wr_req;
    assign cnt_wr_req = req_valid_i && req_write_i && (&req_be_i)
                        && ({1'b0, req_cpu_i} < (CPU_W+1)'(NUM_CPU))
                        && ((req_addr_i == ADDR_W'(0)) || (req_addr_i == ADDR_W'(4)));

    // R3
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !cnt_wr_req) |=> $stable(count_o));

    // R5
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)));

    // R13
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_tick_o |=> (count_o == $past(count_o) + 1'b1));

    // R13
    tick_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_tick_o |-> run_o);

    // R12
    idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && !req_write_i) |-> (rd_data_o == '0));

    // R9
    part_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !(&req_be_i)) |-> (rd_data_o == '0));
endmodule

bind gtmr_global_timer gtmr_global_timer_chk #(
    .NUM_CPU (NUM_CPU),
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/gtmr_global_timer_tb.sv
// Bench for the global timer: a behavioural reference model stepped on every
// clock, compared at every falling edge, plus same-cycle read checks.
module gtmr_global_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [1:0]  req_cpu = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [63:0] count;
    logic        tick;
    logic        run;
    logic [NCPU-1:0] cmp_en, irq_en, auto_inc;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    // Reference model state
    logic [63:0] m_cnt;
    int          m_div;
    bit          m_run;
    int          m_presc;
    logic [2:0]  m_bank [NCPU];

    gtmr_global_timer #(.NUM_CPU(NCPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_be_i(req_be), .req_cpu_i(req_cpu),
        .req_wdata_i(req_wdata), .rd_data_o(rd_data), .count_o(count),
        .count_tick_o(tick), .run_o(run), .cmp_en_o(cmp_en), .irq_en_o(irq_en),
        .auto_inc_o(auto_inc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_div = 0; m_run = 1'b0; m_presc = 0;
            for (int i = 0; i < NCPU; i++) m_bank[i] = '0;
        end else begin
            bit adv;
            bit was_run;
            bit ok;
            adv = m_run && (m_div >= m_presc);
            was_run = m_run;
            if (m_run && !adv) m_div = m_div + 1; else m_div = 0;
            if (adv) m_cnt = m_cnt + 64'd1;
            ok = req_valid && req_write && (req_be == 4'hF) && (int'(req_cpu) < NCPU);
            if (ok) begin
                case (req_addr)
                    5'h00: if (!was_run) m_cnt[31:0] = req_wdata;
                    5'h04: if (!was_run) m_cnt[63:32] = req_wdata;
                    5'h08: begin
                        m_run = req_wdata[0];
                        m_presc = int'(req_wdata[15:8]);
                        m_bank[req_cpu] = req_wdata[3:1];
                    end
                    default: ;
                endcase
            end
        end
        started = 1'b1;
    end

    // Compare registered outputs to the model every cycle.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2 count", count, m_cnt);
            chk("R13 tick", {63'd0, tick}, {63'd0, (m_run && (m_div >= m_presc))});
            chk("R6 run", {63'd0, run}, {63'd0, m_run});
            for (int i = 0; i < NCPU; i++) begin
                chk("R13 banked outputs", {61'd0, auto_inc[i], irq_en[i], cmp_en[i]},
                    {61'd0, m_bank[i]});
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [4:0] a, input logic [3:0] be,
                                           input logic [1:0] cpu);
        if (be != 4'hF || int'(cpu) >= NCPU) return '0;
        case (a)
            5'h00: return m_cnt[31:0];
            5'h04: return m_cnt[63:32];
            5'h08: return {16'h0, 8'(m_presc), 4'h0, m_bank[cpu], m_run};
            default: return '0;
        endcase
    endfunction

    // One access cycle; reads are checked in the same cycle.
    task automatic acc(input string req, input bit wr, input logic [4:0] a,
                       input logic [3:0] be, input logic [1:0] cpu, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be;
        req_cpu = cpu; req_wdata = d;
        #1;
        if (!wr) chk(req, {32'd0, rd_data}, {32'd0, exp_rd(a, be, cpu)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
            #1;
            chk("R12 idle read data", {32'd0, rd_data}, 64'd0);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [1:0] cpu);
        acc("write", 1'b1, a, 4'hF, cpu, d);
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [1:0] cpu);
        acc(req, 1'b0, a, 4'hF, cpu, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1 count after reset", count, 64'd0);
        chk("R1 run after reset", {63'd0, run}, 64'd0);
        rd("R1 control after reset", 5'h08, 2'd0);

        // R4 / R8: load both words while stopped, read back
        wr(5'h00, 32'h1234_5678, 2'd0);
        wr(5'h04, 32'h9abc_def0, 2'd1);
        idle(1);
        rd("R4 low word load", 5'h00, 2'd0);
        rd("R8 high word read", 5'h04, 2'd2);

        // R2: prescaler 0, count every cycle
        wr(5'h08, 32'h0000_0001, 2'd0);
        idle(10);
        rd("R8 running low word", 5'h00, 2'd0);

        // R5: count writes refused while running
        wr(5'h00, 32'h0000_0000, 2'd0);
        wr(5'h04, 32'hffff_ffff, 2'd1);
        idle(2);
        rd("R5 low word unchanged", 5'h00, 2'd0);
        rd("R5 high word unchanged", 5'h04, 2'd0);

        // R3: stop and hold
        wr(5'h08, 32'h0000_0000, 2'd0);
        idle(6);
        rd("R3 held low word", 5'h00, 2'd0);

        // R2 carry into the high word
        wr(5'h00, 32'hffff_fffd, 2'd0);
        wr(5'h04, 32'h0000_0000, 2'd0);
        wr(5'h08, 32'h0000_0001, 2'd0);
        idle(5);
        rd("R2 carry high word", 5'h04, 2'd0);
        wr(5'h08, 32'h0000_0000, 2'd0);
        idle(2);

        // R2: prescaler 3
        wr(5'h08, 32'h0000_0301, 2'd0);
        idle(20);
        rd("R7 control with prescaler", 5'h08, 2'd0);
        wr(5'h08, 32'h0000_0000, 2'd0);
        idle(2);

        // R2: prescaler lowered mid-run from 5 to 1
        wr(5'h08, 32'h0000_0501, 2'd0);
        idle(4);
        wr(5'h08, 32'h0000_0101, 2'd0);
        idle(10);

        // R6 / R7: banked fields per requester
        wr(5'h08, 32'hffff_00ff, 2'd0);
        wr(5'h08, 32'h0000_0205, 2'd1);
        idle(1);
        rd("R7 control read cpu0", 5'h08, 2'd0);
        rd("R7 control read cpu1", 5'h08, 2'd1);
        rd("R7 control read cpu2", 5'h08, 2'd2);
        idle(3);

        // R9: partial byte enables
        acc("R9 partial write", 1'b1, 5'h08, 4'b0111, 2'd0, 32'h0);
        acc("R9 partial read", 1'b0, 5'h08, 4'b0011, 2'd0, 32'h0);
        idle(2);
        rd("R9 control unchanged", 5'h08, 2'd0);

        // R10: undefined and comparator-side offsets
        wr(5'h0C, 32'hffff_ffff, 2'd0);
        wr(5'h10, 32'hffff_ffff, 2'd1);
        wr(5'h18, 32'hffff_ffff, 2'd2);
        wr(5'h02, 32'h0000_0000, 2'd0);
        rd("R10 offset 0x0C reads zero", 5'h0C, 2'd0);
        rd("R10 offset 0x14 reads zero", 5'h14, 2'd1);
        rd("R10 unaligned reads zero", 5'h01, 2'd0);
        idle(2);

        // R11: requester index out of range
        acc("R11 write from index 3", 1'b1, 5'h08, 4'hF, 2'd3, 32'h0);
        acc("R11 read from index 3", 1'b0, 5'h08, 4'hF, 2'd3, 32'h0);
        idle(2);
        rd("R11 control unchanged", 5'h08, 2'd0);

        // R1: reset during a run
        @(negedge clk) begin req_valid = 1'b0; rst_n = 1'b0; end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        chk("R1 count after second reset", count, 64'd0);
        rd("R1 control after second reset", 5'h08, 2'd1);
        idle(2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule